// File: doc/BRIEF.md
# Byte-Lane Masked Synchronous SRAM

This block is a clocked single-port memory. It holds words of four 9-bit lanes, each lane having 8 data bits and one parity bit, 36 bits in all. One clock edge samples a request. That request is a chip select, a write enable, four active-low lane selects, an address and an output enable. A write stores only the lanes whose select is low. A read returns the whole word through an output register. The word appears in the cycle after the address was sampled.

The data pins are shared between the two directions. The block therefore provides the read word and a drive-enable for the bus pad. The drive-enable goes low when output enable is low, after a deselected cycle, and in any cycle that carries write data. A write cycle turns the drivers off even when output enable is high and the previous cycle was a read. Writes commit on the same edge that samples them, with no extra handshake. Address sequencing for bursts and power-down are handled by neighbouring blocks.

Top module: `lane_sram`

## Requirements
- R1: Synchronous reset drives `rd_drive` low and clears `rd_data` to zero in the cycle after the reset edge. It leaves the stored words unchanged.
- R2: A cycle with `sel`=1 and `wr_en`=0 is a read. After its edge, `rd_data` holds the word at `addr`. In the next cycle `rd_drive` is 1 when `oe`=1 and that next cycle is not a write.
- R3: A cycle with `sel`=1 and `wr_en`=1 writes lane i (bits 9i+8 down to 9i of `wr_data`, i = 0..3) only when bit i of `lane_sel_n` is 0. All other lanes keep their contents, and all lane selects high writes nothing.
- R4: With `wr_en`=0, no lane is written, whatever `lane_sel_n` holds.
- R5: With `sel`=0, neither a read nor a write takes place, and `rd_drive` is 0 in the following cycle.
- R6: `rd_drive` is 0 in any cycle where `oe`=0, with no clock edge needed.
- R7: `rd_drive` is 0 in any cycle where `sel`=1 and `wr_en`=1, whatever `oe` is and whatever the previous cycle was.
- R8: A read in the cycle right after a write to the same address returns the newly written lanes.
- R9: All 9 bits of each lane are stored and returned, including bit 8 of the lane (the parity bit).
- R10: `rd_data` changes only after a read edge or a reset edge, and holds its value through write and deselected cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write enable, active high |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit i for lane i |
| addr | input | ADDR_W | Word address (default 8; 19 for the full array) |
| oe | input | 1 | Output enable, active high |
| wr_data | input | 36 | Write data from the shared bus |
| rd_data | output | 36 | Registered read word |
| rd_drive | output | 1 | Drive-enable for the shared bus; 0 means high impedance |

## Verification
Two functions can fall in the same cycle. The read word from the previous edge is ready to be shown on the bus, and a new write wants the bus for its data. The bench sets this up by placing a write directly after a read while `oe` stays high. It then requires `rd_drive` low during that write cycle, which means the bus reads as high impedance. A later read must show that only the selected lanes of the word changed. In the same way, a deselected cycle that follows a read must still show the read word. In the cycle after it, the bus must be released.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_t;

  // Classify a sampled request.
  function automatic cyc_kind_t classify(input logic sel, input logic wr_en);
    if (!sel)
      return CYC_IDLE;
    else if (wr_en)
      return CYC_WRITE;
    else
      return CYC_READ;
  endfunction

endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
  import lane_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel,
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_sel_n,
  output cyc_kind_t        kind,
  output logic [LANES-1:0] lane_wr,
  output logic             rd_en
);

  always_comb begin
    kind  = classify(sel, wr_en);
    rd_en = (kind == CYC_READ);
    for (int i = 0; i < LANES; i++) begin
      lane_wr[i] = (kind == CYC_WRITE) && !lane_sel_n[i];
    end
  end

endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Array write port; no reset so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= wdata;
  end

  // Output register with synchronous reset.
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= mem[addr];
  end

endmodule

// File: rtl/lane_sram_drive.sv
module lane_sram_drive
  import lane_sram_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cyc_kind_t kind,
  input  logic      oe,
  output logic      rd_drive
);

  logic word_ready_q;

  always_ff @(posedge clk) begin
    if (rst)
      word_ready_q <= 1'b0;
    else
      word_ready_q <= (kind == CYC_READ);
  end

  // A write data phase always releases the pads.
  assign rd_drive = word_ready_q && oe && (kind != CYC_WRITE);

endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel,
  input  logic                     wr_en,
  input  logic [LANES-1:0]         lane_sel_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     oe,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  output logic [LANES*LANE_W-1:0]  rd_data,
  output logic                     rd_drive
);

  localparam int WORD_W = LANES * LANE_W;

  cyc_kind_t        kind;
  logic [LANES-1:0] lane_wr;
  logic             rd_en;

  lane_sram_decode #(.LANES(LANES)) u_decode (
    .sel        (sel),
    .wr_en      (wr_en),
    .lane_sel_n (lane_sel_n),
    .kind       (kind),
    .lane_wr    (lane_wr),
    .rd_en      (rd_en)
  );

  logic [WORD_W-1:0] word_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_sram_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (lane_wr[g]),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wr_data[g*LANE_W +: LANE_W]),
      .rdata (word_q[g*LANE_W +: LANE_W])
    );
  end

  lane_sram_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .oe       (oe),
    .rd_drive (rd_drive)
  );

  assign rd_data = word_q;

endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr_en,
  input logic              oe,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_drive
);

  // R1
  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> !rd_drive);

  // R2
  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr_en) |=> ((oe && !(sel && wr_en)) |-> rd_drive));

  // R5
  a_r5_deselect_release: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !rd_drive);

  // R6
  a_r6_oe_low_release: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !rd_drive);

  // R7
  a_r7_write_phase_z: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en) |-> !rd_drive);

  // R10
  a_r10_hold_word: assert property (@(posedge clk) disable iff (rst)
    !(sel && !wr_en) |=> $stable(rd_data));

endmodule

bind lane_sram lane_sram_chk #(.WORD_W(LANES*LANE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel      (sel),
  .wr_en    (wr_en),
  .oe       (oe),
  .rd_data  (rd_data),
  .rd_drive (rd_drive)
);

// File: tb/test_lane_sram.sv
`timescale 1ns/1ps
module test_lane_sram;

  localparam int AW = 8;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel, wr_en, oe;
  logic [3:0]  lane_sel_n;
  logic [AW-1:0] addr;
  logic [35:0] wr_data;
  logic [35:0] rd_data;
  logic        rd_drive;

  always #2 clk = ~clk;

  lane_sram #(.ADDR_W(AW)) i_lane_sram (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .lane_sel_n(lane_sel_n),
    .addr(addr), .oe(oe), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state
  logic [35:0] ref_mem [1<<AW];
  logic [35:0] exp_word;
  logic        exp_ready;

  // {tag[3:0], sel, we, lsn[3:0], oe, addr[7:0], data[35:0]}
  localparam logic [54:0] VEC [NV] = '{
    {4'd9, 1'b1, 1'b1, 4'b0000, 1'b1, 8'h10, 36'h9A5C3E1F7}, // R9 full write
    {4'd8, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h10, 36'h000000000}, // R8 read after write
    {4'd7, 1'b1, 1'b1, 4'b0000, 1'b1, 8'h11, 36'h123456789}, // R7 write right after read
    {4'd2, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h11, 36'h000000000}, // R2 read
    {4'd3, 1'b1, 1'b1, 4'b1010, 1'b1, 8'h10, 36'hFFFFFFFFF}, // R3 lanes 0,2
    {4'd3, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h10, 36'h000000000}, // R3 read back
    {4'd6, 1'b1, 1'b0, 4'b0000, 1'b0, 8'h11, 36'h000000000}, // R6 oe low
    {4'd5, 1'b0, 1'b1, 4'b0000, 1'b1, 8'h11, 36'h000000000}, // R5 deselected write
    {4'd4, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h11, 36'h000000000}, // R4/R5 unchanged
    {4'd3, 1'b1, 1'b1, 4'b1111, 1'b1, 8'h11, 36'h000000000}, // R3 no lanes
    {4'd3, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h11, 36'h000000000}, // R3 read
    {4'd9, 1'b1, 1'b1, 4'b0111, 1'b1, 8'h11, 36'hAAAAAAAAA}, // R9 lane 3 incl parity
    {4'd9, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h11, 36'h000000000}, // R9 read
    {4'd2, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h10, 36'h000000000}, // R2 back-to-back read
    {4'd5, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h10, 36'h000000000}, // R5 idle after read
    {4'd10,1'b0, 1'b0, 4'b0000, 1'b1, 8'h10, 36'h000000000}  // R10 hold
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive, check outputs of this cycle, then update the model.
  task automatic cycle(input string req, input logic r, input logic s, input logic w,
                       input logic [3:0] lsn, input logic o, input logic [AW-1:0] a,
                       input logic [35:0] d);
    bit exp_drv;
    @(negedge clk);
    rst = r; sel = s; wr_en = w; lane_sel_n = lsn; oe = o; addr = a; wr_data = d;
    #1;
    exp_drv = exp_ready && o && !(s && w);
    check(rd_drive === exp_drv, req, "rd_drive", {35'd0, rd_drive}, {35'd0, exp_drv});
    check(rd_data === exp_word, req, "rd_data", rd_data, exp_word);
    @(posedge clk);
    if (r) begin
      exp_ready = 1'b0;
      exp_word  = '0;
    end else begin
      exp_ready = s && !w;
      if (s && !w) exp_word = ref_mem[a];
      if (s && w) begin
        for (int i = 0; i < 4; i++)
          if (!lsn[i]) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel = 0; wr_en = 0; lane_sel_n = 4'hF; oe = 0; addr = '0; wr_data = '0;
    exp_ready = 1'b0; exp_word = '0;
    repeat (2) @(posedge clk);
    // R1 reset state
    cycle("R1", 1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h00, 36'h0);
    cycle("R1", 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 8'h00, 36'h0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[k][54:51]);
      cycle(tag, 1'b0, VEC[k][50], VEC[k][49], VEC[k][48:45], VEC[k][44],
            VEC[k][43:36], VEC[k][35:0]);
    end

    // R7: write directly after a read with oe high, bus must be released
    cycle("R7", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h10, 36'h0);
    cycle("R7", 1'b0, 1'b1, 1'b1, 4'b1110, 1'b1, 8'h10, 36'h000000155);
    cycle("R3", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h10, 36'h0);
    // R6: oe dropped then raised while word is ready
    cycle("R6", 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h11, 36'h0);
    cycle("R6", 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 8'h11, 36'h0);
    // R4: write enable low with all lanes selected behaves as a read
    cycle("R4", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h11, 36'hFFFFFFFFF);
    cycle("R4", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h11, 36'h0);
    // R1: reset after a read clears output, keeps memory
    cycle("R1", 1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h11, 36'h0);
    cycle("R1", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h11, 36'h0);
    cycle("R1", 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 8'h11, 36'h0);
    cycle("R10", 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 8'h11, 36'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule